// File: doc/BRIEF.md
# Runtime-configurable serial echo port

This block is an asynchronous serial port. It has one transmitter and one receiver, and both use a single frame format. The format comes from a control word that the block copies in while it is idle. The control word selects the number of data bits (5 to 8), the parity mode (none, odd, even, forced one, forced zero), one or two stop bits, the clocks-per-bit divisor and an echo switch. A format change therefore takes effect at run time without a reset, and it never alters a frame that is already on the wire.

With echo off, received characters go to a valid/ready output and the transmitter takes characters from a valid/ready input. With echo on, each character received without error is passed through a one-entry holding register straight into the transmitter. In that mode the external transmit handshake is shut off. After reset the block comes up as an echo device: 8 data bits, no parity, one stop bit, and a divisor of clock frequency divided by baud rate (868 for 100 MHz and 115200 baud).

Top module: `uart_echo_core`

## Requirements
- R1: After reset, `tx_o` is 1, `rx_valid_o` is 0, `tx_ready_o` is 0 (echo is on by default), and `parity_err_o`, `frame_err_o` and `overrun_o` are 0.
- R2: The control word `cfg_i` has these fields:
  - bits [1:0]: data length minus 5.
  - bits [4:2]: parity, with 0 none, 1 odd, 2 even, 3 forced one and 4 forced zero. Codes 5 to 7 mean none.
  - bit 5: two stop bits when set.
  - bit 6: echo.
  - bits [22:7]: divisor. A divisor below 4 is used as 4.

  The word is copied only in a cycle where the receiver is idle, the transmitter is idle and the holding register is empty. A frame that is in progress keeps its format.
- R3: A transmitted frame consists of the following, with each bit lasting divisor clocks and `tx_o` held high between frames:
  - a low start bit;
  - the data bits, least significant first;
  - the parity bit, if enabled (odd: total count of ones odd; even: count even);
  - the stop bits, high.
- R4: `tx_ready_o` is high only when the transmitter is idle and echo is off. A cycle with `tx_valid_i` and `tx_ready_o` both high starts exactly one frame with `tx_data_i`, and `tx_ready_o` drops in the next cycle. In echo mode, `tx_valid_i` has no effect on `tx_o`.
- R5: The receiver passes `rx_i` through two flip-flops and samples each bit at its midpoint. If the line is high again half a bit after a falling edge, that edge is ignored and no character is produced.
- R6: With echo off, a received character appears on `rx_data_o`, zero-extended above the data length. `rx_valid_o` and `rx_data_o` hold until a cycle with `rx_ready_i` high.
- R7: `parity_err_o` shows whether the most recently completed character had a parity bit that did not match the selected mode.
- R8: `frame_err_o` shows whether the most recently completed character had a low stop bit. After such a frame, the receiver waits for the line to go high before it looks for a new start bit.
- R9: In echo mode, a character received without error is retransmitted in the same format, and `rx_valid_o` stays 0. A character with a parity or framing error is not retransmitted.
- R10: A character that completes while the holding register is full and not being emptied that cycle is dropped. `overrun_o` then shows 1 until the next character completes, and the held character is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_i | input | 23 | Control word (frame format, echo, divisor) |
| rx_i | input | 1 | Serial receive line, idles high |
| tx_o | output | 1 | Serial transmit line, idles high |
| rx_data_o | output | 8 | Received character, zero-extended |
| rx_valid_o | output | 1 | Received character available |
| rx_ready_i | input | 1 | Consumer takes the received character |
| tx_data_i | input | 8 | Character to transmit |
| tx_valid_i | input | 1 | Character to transmit is offered |
| tx_ready_o | output | 1 | Transmitter idle and accepting |
| parity_err_o | output | 1 | Parity error on last character |
| frame_err_o | output | 1 | Framing error on last character |
| overrun_o | output | 1 | Last character was dropped |

## Verification
The assertions assume the following about the inputs:
- The consumer leaves `rx_ready_i` low for as long as it wants a held character kept.
- `cfg_i` is free to change at any time; the block itself freezes the format while any frame is active.
- The serial line follows whole bit periods at the divisor that is currently latched.

The stimulus keeps within these limits. It drives `rx_i` only in bit periods that are whole multiples of the latched divisor, except for the deliberate short glitch. It changes `cfg_i` mid-frame only to show that the frame in progress keeps its format. It moves all inputs just after a rising edge and reads outputs on the falling edge.

// File: rtl/uart_cfg_pkg.sv
package uart_cfg_pkg;

    localparam int DIV_W    = 16;
    localparam int MAX_BITS = 8;
    localparam int MIN_DIV  = 4;

    typedef struct packed {
        logic [DIV_W-1:0] div;
        logic             echo;
        logic             stop2;
        logic [2:0]       par;
        logic [1:0]       len;
    } cfg_t;

    localparam int CFG_W = $bits(cfg_t);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP,
        ST_WAIT
    } ser_st_t;

    function automatic logic par_on(input logic [2:0] p);
        return (p >= 3'd1) && (p <= 3'd4);
    endfunction

    function automatic logic [3:0] n_bits(input logic [1:0] len);
        return 4'd5 + {2'b00, len};
    endfunction

    function automatic logic [MAX_BITS-1:0] len_mask(input logic [1:0] len);
        return 8'hFF >> (2'd3 - len);
    endfunction

    function automatic logic par_bit(input logic [MAX_BITS-1:0] d,
                                     input logic [1:0] len,
                                     input logic [2:0] p);
        logic [MAX_BITS-1:0] dm;
        dm = d & len_mask(len);
        case (p)
            3'd1:    return ~(^dm);
            3'd2:    return ^dm;
            3'd3:    return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/uart_cfg_latch.sv
module uart_cfg_latch
    import uart_cfg_pkg::*;
#(
    parameter int DEF_DIV = 868
) (
    input  logic clk,
    input  logic rst,
    input  cfg_t cfg_in,
    input  logic may_load,
    output cfg_t cfg_q
);
    localparam logic [DIV_W-1:0] RST_DIV = DIV_W'(DEF_DIV);
    localparam logic [DIV_W-1:0] LOW_DIV = DIV_W'(MIN_DIV);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q.len   <= 2'd3;
            cfg_q.par   <= 3'd0;
            cfg_q.stop2 <= 1'b0;
            cfg_q.echo  <= 1'b1;
            cfg_q.div   <= RST_DIV;
        end else if (may_load) begin
            cfg_q.len   <= cfg_in.len;
            cfg_q.par   <= cfg_in.par;
            cfg_q.stop2 <= cfg_in.stop2;
            cfg_q.echo  <= cfg_in.echo;
            cfg_q.div   <= (cfg_in.div < LOW_DIV) ? LOW_DIV : cfg_in.div;
        end
    end
endmodule

// File: rtl/uart_rx.sv
module uart_rx
    import uart_cfg_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                rx_i,
    input  logic [1:0]          len,
    input  logic [2:0]          par,
    input  logic                stop2,
    input  logic [DIV_W-1:0]    div,
    output logic                done,
    output logic [MAX_BITS-1:0] data,
    output logic                perr,
    output logic                ferr,
    output logic                idle
);
    logic            sync1, sync2;
    ser_st_t         st;
    logic [DIV_W-1:0] cnt;
    logic [2:0]      bit_i;
    logic            stop_i;
    logic            bit_end, half_end;

    assign bit_end  = (cnt == div - 1'b1);
    assign half_end = (cnt == (div >> 1) - 1'b1);
    assign idle     = (st == ST_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            sync1 <= 1'b1;
            sync2 <= 1'b1;
        end else begin
            sync1 <= rx_i;
            sync2 <= sync1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= ST_IDLE;
            cnt    <= '0;
            bit_i  <= '0;
            stop_i <= 1'b0;
            data   <= '0;
            perr   <= 1'b0;
            ferr   <= 1'b0;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (st)
                ST_IDLE: begin
                    cnt <= '0;
                    if (!sync2) st <= ST_START;
                end
                ST_START: begin
                    if (half_end) begin
                        cnt <= '0;
                        if (sync2) begin
                            st <= ST_IDLE;
                        end else begin
                            st    <= ST_DATA;
                            bit_i <= '0;
                            data  <= '0;
                            perr  <= 1'b0;
                            ferr  <= 1'b0;
                        end
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_DATA: begin
                    if (bit_end) begin
                        cnt         <= '0;
                        data[bit_i] <= sync2;
                        if ({1'b0, bit_i} == n_bits(len) - 4'd1) begin
                            st     <= par_on(par) ? ST_PAR : ST_STOP;
                            stop_i <= 1'b0;
                        end else begin
                            bit_i <= bit_i + 1'b1;
                        end
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_PAR: begin
                    if (bit_end) begin
                        cnt  <= '0;
                        perr <= (sync2 != par_bit(data, len, par));
                        st   <= ST_STOP;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_STOP: begin
                    if (bit_end) begin
                        cnt  <= '0;
                        ferr <= ferr | ~sync2;
                        if (stop2 && !stop_i) begin
                            stop_i <= 1'b1;
                        end else begin
                            done <= 1'b1;
                            st   <= sync2 ? ST_IDLE : ST_WAIT;
                        end
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_WAIT: begin
                    if (sync2) st <= ST_IDLE;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/uart_tx.sv
module uart_tx
    import uart_cfg_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [1:0]          len,
    input  logic [2:0]          par,
    input  logic                stop2,
    input  logic [DIV_W-1:0]    div,
    input  logic                start,
    input  logic [MAX_BITS-1:0] din,
    output logic                tx_o,
    output logic                idle
);
    ser_st_t             st;
    logic [DIV_W-1:0]    cnt;
    logic [2:0]          bit_i;
    logic                stop_i;
    logic [MAX_BITS-1:0] sh;
    logic                pbit;
    logic                bit_end;

    assign bit_end = (cnt == div - 1'b1);
    assign idle    = (st == ST_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= ST_IDLE;
            cnt    <= '0;
            bit_i  <= '0;
            stop_i <= 1'b0;
            sh     <= '0;
            pbit   <= 1'b0;
            tx_o   <= 1'b1;
        end else begin
            unique case (st)
                ST_IDLE: begin
                    tx_o <= 1'b1;
                    cnt  <= '0;
                    if (start) begin
                        sh   <= din;
                        pbit <= par_bit(din, len, par);
                        tx_o <= 1'b0;
                        st   <= ST_START;
                    end
                end
                ST_START: begin
                    if (bit_end) begin
                        cnt   <= '0;
                        bit_i <= '0;
                        tx_o  <= sh[0];
                        st    <= ST_DATA;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_DATA: begin
                    if (bit_end) begin
                        cnt <= '0;
                        if ({1'b0, bit_i} == n_bits(len) - 4'd1) begin
                            stop_i <= 1'b0;
                            if (par_on(par)) begin
                                tx_o <= pbit;
                                st   <= ST_PAR;
                            end else begin
                                tx_o <= 1'b1;
                                st   <= ST_STOP;
                            end
                        end else begin
                            bit_i <= bit_i + 1'b1;
                            tx_o  <= sh[1];
                            sh    <= sh >> 1;
                        end
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_PAR: begin
                    if (bit_end) begin
                        cnt  <= '0;
                        tx_o <= 1'b1;
                        st   <= ST_STOP;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_STOP: begin
                    if (bit_end) begin
                        cnt <= '0;
                        if (stop2 && !stop_i) stop_i <= 1'b1;
                        else                  st     <= ST_IDLE;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/uart_echo_core.sv
module uart_echo_core
    import uart_cfg_pkg::*;
#(
    parameter int CLK_HZ = 100_000_000,
    parameter int BAUD   = 115_200
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [CFG_W-1:0]    cfg_i,
    input  logic                rx_i,
    output logic                tx_o,
    output logic [MAX_BITS-1:0] rx_data_o,
    output logic                rx_valid_o,
    input  logic                rx_ready_i,
    input  logic [MAX_BITS-1:0] tx_data_i,
    input  logic                tx_valid_i,
    output logic                tx_ready_o,
    output logic                parity_err_o,
    output logic                frame_err_o,
    output logic                overrun_o
);
    localparam int DEF_DIV = CLK_HZ / BAUD;

    cfg_t                cfg_q;
    logic                may_load;
    logic                rx_done, rx_perr, rx_ferr, rx_idle;
    logic [MAX_BITS-1:0] rx_data;
    logic                tx_idle, tx_start;
    logic [MAX_BITS-1:0] tx_din;
    logic                hold_v;
    logic [MAX_BITS-1:0] hold_d;
    logic                echo, drain, want_store, room;
    logic                perr_q, ferr_q, ovr_q;

    assign echo       = cfg_q.echo;
    assign tx_start   = tx_idle && (echo ? hold_v : tx_valid_i);
    assign tx_din     = echo ? hold_d : tx_data_i;
    assign drain      = echo ? tx_start : (hold_v && rx_ready_i);
    assign want_store = rx_done && (!echo || !(rx_perr || rx_ferr));
    assign room       = !hold_v || drain;
    assign may_load   = rx_idle && tx_idle && !hold_v && !tx_start && !rx_done;

    uart_cfg_latch #(.DEF_DIV(DEF_DIV)) u_cfg (
        .clk      (clk),
        .rst      (rst),
        .cfg_in   (cfg_t'(cfg_i)),
        .may_load (may_load),
        .cfg_q    (cfg_q)
    );

    uart_rx u_rx (
        .clk   (clk),
        .rst   (rst),
        .rx_i  (rx_i),
        .len   (cfg_q.len),
        .par   (cfg_q.par),
        .stop2 (cfg_q.stop2),
        .div   (cfg_q.div),
        .done  (rx_done),
        .data  (rx_data),
        .perr  (rx_perr),
        .ferr  (rx_ferr),
        .idle  (rx_idle)
    );

    uart_tx u_tx (
        .clk   (clk),
        .rst   (rst),
        .len   (cfg_q.len),
        .par   (cfg_q.par),
        .stop2 (cfg_q.stop2),
        .div   (cfg_q.div),
        .start (tx_start),
        .din   (tx_din),
        .tx_o  (tx_o),
        .idle  (tx_idle)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_v <= 1'b0;
            hold_d <= '0;
            perr_q <= 1'b0;
            ferr_q <= 1'b0;
            ovr_q  <= 1'b0;
        end else begin
            if (drain) hold_v <= 1'b0;
            if (want_store && room) begin
                hold_v <= 1'b1;
                hold_d <= rx_data;
            end
            if (rx_done) begin
                perr_q <= rx_perr;
                ferr_q <= rx_ferr;
                ovr_q  <= want_store && !room;
            end
        end
    end

    assign rx_data_o    = hold_d;
    assign rx_valid_o   = hold_v && !echo;
    assign tx_ready_o   = tx_idle && !echo;
    assign parity_err_o = perr_q;
    assign frame_err_o  = ferr_q;
    assign overrun_o    = ovr_q;
endmodule

// File: rtl/uart_echo_core_chk.sv
module uart_echo_core_chk
    import uart_cfg_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic                tx_o,
    input logic                tx_ready_o,
    input logic                tx_valid_i,
    input logic                rx_valid_o,
    input logic                rx_ready_i,
    input logic [MAX_BITS-1:0] rx_data_o,
    input logic                rx_idle,
    input cfg_t                cfg_word
);
    assert_idle_high_R4: assert property (@(posedge clk) disable iff (rst)
        tx_ready_o |-> tx_o);

    assert_accept_start_R3: assert property (@(posedge clk) disable iff (rst)
        (tx_valid_i && tx_ready_o) |=> (!tx_o && !tx_ready_o));

    assert_rx_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (rx_valid_o && !rx_ready_i) |=> (rx_valid_o && $stable(rx_data_o)));

    assert_cfg_frozen_R2: assert property (@(posedge clk) disable iff (rst)
        !rx_idle |=> $stable(cfg_word));

    assert_echo_silent_R9: assert property (@(posedge clk) disable iff (rst)
        cfg_word.echo |-> !rx_valid_o);
endmodule

bind uart_echo_core uart_echo_core_chk chk_i (
    .clk        (clk),
    .rst        (rst),
    .tx_o       (tx_o),
    .tx_ready_o (tx_ready_o),
    .tx_valid_i (tx_valid_i),
    .rx_valid_o (rx_valid_o),
    .rx_ready_i (rx_ready_i),
    .rx_data_o  (rx_data_o),
    .rx_idle    (rx_idle),
    .cfg_word   (cfg_q)
);

// File: tb/uart_echo_core_tb_top.sv
module uart_echo_core_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int DEF_DIV    = 868;

    typedef struct packed {
        logic [1:0] len;
        logic [2:0] par;
        logic       s2;
        logic [7:0] dv;
        logic [7:0] d;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{2'd3, 3'd0, 1'b0, 8'd16, 8'hA5},
        '{2'd0, 3'd1, 1'b1, 8'd10, 8'h13},
        '{2'd1, 3'd2, 1'b0, 8'd12, 8'h2D},
        '{2'd2, 3'd3, 1'b1, 8'd8,  8'h55},
        '{2'd3, 3'd4, 1'b0, 8'd20, 8'hC3},
        '{2'd0, 3'd0, 1'b0, 8'd8,  8'hFF}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [22:0] cfg_i;
    logic        rx_drv = 1'b1;
    logic        tx_o;
    logic [7:0]  rx_data_o;
    logic        rx_valid_o;
    logic        rx_ready_i = 1'b0;
    logic [7:0]  tx_data_i = 8'h00;
    logic        tx_valid_i = 1'b0;
    logic        tx_ready_o;
    logic        parity_err_o, frame_err_o, overrun_o;

    int total = 0;
    int fails = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    uart_echo_core dut_i (
        .clk          (clk),
        .rst          (rst),
        .cfg_i        (cfg_i),
        .rx_i         (rx_drv),
        .tx_o         (tx_o),
        .rx_data_o    (rx_data_o),
        .rx_valid_o   (rx_valid_o),
        .rx_ready_i   (rx_ready_i),
        .tx_data_i    (tx_data_i),
        .tx_valid_i   (tx_valid_i),
        .tx_ready_o   (tx_ready_o),
        .parity_err_o (parity_err_o),
        .frame_err_o  (frame_err_o),
        .overrun_o    (overrun_o)
    );

    function automatic logic [22:0] mk_cfg(input logic [1:0] len, input logic [2:0] par,
                                           input logic s2, input logic echo, input int dv);
        logic [15:0] d16;
        d16 = 16'(dv);
        return {d16, echo, s2, par, len};
    endfunction

    function automatic logic exp_par(input logic [7:0] d, input int n, input logic [2:0] p);
        int ones;
        ones = 0;
        for (int i = 0; i < n; i++) ones += int'(d[i]);
        case (p)
            3'd1:    return (ones % 2) == 0;
            3'd2:    return (ones % 2) == 1;
            3'd3:    return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    function automatic bit has_par(input logic [2:0] p);
        return (p == 3'd1) || (p == 3'd2) || (p == 3'd3) || (p == 3'd4);
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", total - fails, total);
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic send_rx(input logic [7:0] d, input int n, input logic [2:0] p, input bit s2,
                           input int dv, input bit bad_par, input bit bad_stop);
        @(posedge clk); #1;
        rx_drv = 1'b0;
        wait_cyc(dv);
        for (int i = 0; i < n; i++) begin
            rx_drv = d[i];
            wait_cyc(dv);
        end
        if (has_par(p)) begin
            rx_drv = exp_par(d, n, p) ^ bad_par;
            wait_cyc(dv);
        end
        for (int s = 0; s < (s2 ? 2 : 1); s++) begin
            rx_drv = !bad_stop;
            wait_cyc(dv);
        end
        rx_drv = 1'b1;
        wait_cyc(dv);
    endtask

    task automatic capture_tx(input int n, input logic [2:0] p, input bit s2, input int dv,
                              input logic [7:0] d, input string tag);
        int bad;
        int guard;
        bad = 0;
        guard = 0;
        @(negedge clk);
        while (tx_o === 1'b1 && guard < 40 * dv + 1000) begin
            @(negedge clk);
            guard++;
        end
        if (tx_o !== 1'b0) bad = 100;
        repeat (dv / 2) @(negedge clk);
        if (tx_o !== 1'b0) bad++;
        for (int i = 0; i < n; i++) begin
            repeat (dv) @(negedge clk);
            if (tx_o !== d[i]) bad++;
        end
        if (has_par(p)) begin
            repeat (dv) @(negedge clk);
            if (tx_o !== exp_par(d, n, p)) bad++;
        end
        for (int s = 0; s < (s2 ? 2 : 1); s++) begin
            repeat (dv) @(negedge clk);
            if (tx_o !== 1'b1) bad++;
        end
        check(bad == 0, tag, bad, 0);
    endtask

    task automatic send_tx(input logic [7:0] d);
        @(posedge clk); #1;
        tx_valid_i = 1'b1;
        tx_data_i  = d;
        @(negedge clk);
        while (!tx_ready_o) @(negedge clk);
        @(posedge clk); #1;
        tx_valid_i = 1'b0;
        @(negedge clk);
        check(tx_ready_o == 1'b0, "R4 ready drops after accept", int'(tx_ready_o), 0);
    endtask

    task automatic drain_rx();
        @(posedge clk); #1;
        rx_ready_i = 1'b1;
        @(posedge clk); #1;
        rx_ready_i = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        total++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        summary();
        $finish;
    end

    initial begin
        int lows;
        int n;
        logic [7:0] ex;
        cfg_i = mk_cfg(2'd3, 3'd0, 1'b0, 1'b1, DEF_DIV);
        wait_cyc(5);
        @(negedge clk);
        // R1 reset state
        check(tx_o == 1'b1, "R1 tx_o idle", int'(tx_o), 1);
        check(rx_valid_o == 1'b0, "R1 rx_valid_o", int'(rx_valid_o), 0);
        check(tx_ready_o == 1'b0, "R1 tx_ready_o", int'(tx_ready_o), 0);
        check({parity_err_o, frame_err_o, overrun_o} == 3'b000, "R1 flags",
              int'({parity_err_o, frame_err_o, overrun_o}), 0);
        @(posedge clk); #1;
        rst = 1'b0;
        wait_cyc(4);

        // R9 default 8N1 echo at the reset divisor
        fork
            send_rx(8'h5A, 8, 3'd0, 1'b0, DEF_DIV, 1'b0, 1'b0);
            capture_tx(8, 3'd0, 1'b0, DEF_DIV, 8'h5A, "R9 default echo frame");
        join
        wait_cyc(DEF_DIV);
        @(negedge clk);
        check(rx_valid_o == 1'b0, "R9 no rx_valid in echo", int'(rx_valid_o), 0);

        // R4 tx_valid_i ignored in echo mode
        @(posedge clk); #1;
        tx_valid_i = 1'b1;
        tx_data_i  = 8'h00;
        lows = 0;
        repeat (300) begin
            @(negedge clk);
            if (tx_o !== 1'b1 || tx_ready_o !== 1'b0) lows++;
        end
        tx_valid_i = 1'b0;
        check(lows == 0, "R4 tx_valid ignored in echo", lows, 0);

        // Vector table: R3 transmit format, R6 receive delivery
        foreach (VECS[k]) begin
            cfg_i = mk_cfg(VECS[k].len, VECS[k].par, VECS[k].s2, 1'b0, int'(VECS[k].dv));
            wait_cyc(8);
            n  = 5 + int'(VECS[k].len);
            ex = VECS[k].d & (8'hFF >> (3 - int'(VECS[k].len)));
            fork
                send_tx(VECS[k].d);
                capture_tx(n, VECS[k].par, VECS[k].s2, int'(VECS[k].dv), VECS[k].d, "R3 vector frame");
            join
            send_rx(VECS[k].d, n, VECS[k].par, VECS[k].s2, int'(VECS[k].dv), 1'b0, 1'b0);
            @(negedge clk);
            check(rx_valid_o == 1'b1, "R6 vector rx_valid", int'(rx_valid_o), 1);
            check(rx_data_o == ex, "R6 vector rx_data", int'(rx_data_o), int'(ex));
            check(parity_err_o == 1'b0, "R7 vector no parity error", int'(parity_err_o), 0);
            check(frame_err_o == 1'b0, "R8 vector no frame error", int'(frame_err_o), 0);
            drain_rx();
            check(rx_valid_o == 1'b0, "R6 drained", int'(rx_valid_o), 0);
        end

        // R2 format held during a frame, new format applies to the next one
        cfg_i = mk_cfg(2'd3, 3'd0, 1'b0, 1'b0, 16);
        wait_cyc(8);
        fork
            send_tx(8'h3C);
            capture_tx(8, 3'd0, 1'b0, 16, 8'h3C, "R2 old format kept mid-frame");
            begin
                wait_cyc(40);
                cfg_i = mk_cfg(2'd2, 3'd2, 1'b1, 1'b0, 12);
            end
        join
        wait_cyc(8);
        fork
            send_tx(8'h3C);
            capture_tx(7, 3'd2, 1'b1, 12, 8'h3C, "R2 new format next frame");
        join

        // R2 divisor below the minimum runs as 4
        cfg_i = mk_cfg(2'd3, 3'd0, 1'b0, 1'b0, 1);
        wait_cyc(8);
        fork
            send_tx(8'h96);
            capture_tx(8, 3'd0, 1'b0, 4, 8'h96, "R2 divisor clamp");
        join

        // R5 false start is ignored
        cfg_i = mk_cfg(2'd3, 3'd0, 1'b0, 1'b0, 16);
        wait_cyc(8);
        rx_drv = 1'b0;
        wait_cyc(3);
        rx_drv = 1'b1;
        wait_cyc(64);
        @(negedge clk);
        check(rx_valid_o == 1'b0, "R5 glitch rejected", int'(rx_valid_o), 0);
        send_rx(8'h81, 8, 3'd0, 1'b0, 16, 1'b0, 1'b0);
        @(negedge clk);
        check(rx_valid_o == 1'b1 && rx_data_o == 8'h81, "R5 char after glitch", int'(rx_data_o), 8'h81);
        drain_rx();

        // R7 parity error
        cfg_i = mk_cfg(2'd3, 3'd2, 1'b0, 1'b0, 16);
        wait_cyc(8);
        send_rx(8'h47, 8, 3'd2, 1'b0, 16, 1'b1, 1'b0);
        @(negedge clk);
        check(parity_err_o == 1'b1, "R7 parity error flagged", int'(parity_err_o), 1);
        check(rx_data_o == 8'h47, "R7 data with parity error", int'(rx_data_o), 8'h47);
        drain_rx();

        // R8 framing error, no spurious character after it
        cfg_i = mk_cfg(2'd3, 3'd0, 1'b0, 1'b0, 16);
        wait_cyc(8);
        send_rx(8'h6E, 8, 3'd0, 1'b0, 16, 1'b0, 1'b1);
        @(negedge clk);
        check(frame_err_o == 1'b1, "R8 framing error flagged", int'(frame_err_o), 1);
        drain_rx();
        wait_cyc(40);
        @(negedge clk);
        check(rx_valid_o == 1'b0, "R8 no extra char after break", int'(rx_valid_o), 0);
        send_rx(8'h24, 8, 3'd0, 1'b0, 16, 1'b0, 1'b0);
        @(negedge clk);
        check(frame_err_o == 1'b0 && rx_data_o == 8'h24, "R8 recovery", int'(frame_err_o), 0);
        drain_rx();

        // R10 overrun keeps first character, drops second
        send_rx(8'h11, 8, 3'd0, 1'b0, 16, 1'b0, 1'b0);
        send_rx(8'h22, 8, 3'd0, 1'b0, 16, 1'b0, 1'b0);
        @(negedge clk);
        check(overrun_o == 1'b1, "R10 overrun flagged", int'(overrun_o), 1);
        check(rx_valid_o == 1'b1 && rx_data_o == 8'h11, "R10 first char kept", int'(rx_data_o), 8'h11);
        drain_rx();
        send_rx(8'h33, 8, 3'd0, 1'b0, 16, 1'b0, 1'b0);
        @(negedge clk);
        check(overrun_o == 1'b0 && rx_data_o == 8'h33, "R10 overrun clears", int'(overrun_o), 0);
        drain_rx();

        // R9 echo drops a character with a parity error, echoes a good one
        cfg_i = mk_cfg(2'd3, 3'd1, 1'b0, 1'b1, 16);
        wait_cyc(8);
        lows = 0;
        fork
            send_rx(8'h5C, 8, 3'd1, 1'b0, 16, 1'b1, 1'b0);
            repeat (20 * 16) begin
                @(negedge clk);
                if (tx_o !== 1'b1) lows++;
            end
        join
        check(lows == 0, "R9 bad char not echoed", lows, 0);
        check(parity_err_o == 1'b1, "R9 echo parity flag", int'(parity_err_o), 1);
        fork
            send_rx(8'hE1, 8, 3'd1, 1'b0, 16, 1'b0, 1'b0);
            capture_tx(8, 3'd1, 1'b0, 16, 8'hE1, "R9 echo odd parity");
        join

        summary();
        $finish;
    end
endmodule